// File: doc/BRIEF.md
# Framed Serial Word Transmitter

This block sends a parallel word over a single data line with a forwarded bit clock and an active-low frame strobe, all generated from one system clock. A single-cycle start request latches the word and opens a frame. The block then shifts out exactly one word, most significant bit first, and closes the frame. The frame strobe brackets every word. A receiver therefore locks to word boundaries from the first frame after power-up, with no guessing at the bit position.

The bit clock is the system clock divided by an even parameter `DIV`. It idles low and toggles only inside a frame. Serial data changes on bit-clock falling edges, so a receiver samples it on rising edges and shifts left to rebuild the word. A busy output covers the frame and a guard gap of one bit period that follows it. Start requests are ignored while busy is high.

Top module: `frame_serial_tx`

## Requirements
- R1: Each frame contains exactly `W` (default 12) rising edges of `bck_o` while `frame_o` is low.
- R2: Bits leave MSB first. Bits sampled on rising `bck_o` edges and shifted in from the right rebuild the word. For example, 0xABD appears as 1,0,1,0,1,0,1,1,1,1,0,1.
- R3: `data_o` never changes in a cycle in which `bck_o` rises. Each bit is stable around its rising edge.
- R4: `frame_o` is active low and stays low for exactly `W*DIV` system cycles per frame. `data_o` is 0 while `frame_o` is high.
- R5: `bck_o` has period `DIV` cycles. It is low whenever `frame_o` is high and toggles only during a frame.
- R6: The first rising edge of `bck_o` comes `DIV/2` cycles after `frame_o` falls. `frame_o` rises together with the falling edge that follows the last rising edge.
- R7: `start_i` is ignored while `busy_o` is high. With `start_i` held high, `frame_o` stays high for exactly `DIV+1` cycles between frames.
- R8: `word_i` is captured in the cycle the start is accepted. Later changes do not alter the frame in flight.
- R9: When `rst_ni` is low, `frame_o` is 1 and `bck_o`, `data_o` and `busy_o` are 0, including when reset is applied mid-frame.
- R10: `busy_o` rises with the start of the frame. It stays high for the frame plus `DIV` further cycles, and is high whenever `frame_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start request, sampled when idle |
| word_i | input | W | Parallel word to send |
| bck_o | output | 1 | Forwarded bit clock |
| data_o | output | 1 | Serial data, MSB first |
| frame_o | output | 1 | Frame strobe, active low |
| busy_o | output | 1 | High from accepted start to end of guard gap |

## Verification
The bench sends every possible 12-bit word through the block, so each bit position is driven both high and low against every neighbour pattern. This separates a wrong bit order, a stuck or dropped bit and an off-by-one shift. For each frame it also measures the frame length, the position of the first rising edge and the data stability at every rising edge. Further runs cover these cases:
- the input word is inverted right after the start, which exposes a missing capture;
- start is pulsed mid-frame, which must have no effect;
- start is held high continuously, which fixes the inter-frame gap;
- reset is applied in the middle of a frame.

// File: rtl/ftx_pkg.sv
package ftx_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SEND = 2'd1,
    ST_GAP  = 2'd2
  } ftx_state_e;
endpackage

// File: rtl/ftx_clk_div.sv
module ftx_clk_div #(
  parameter int unsigned HALF = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic tick_o
);
  localparam int unsigned CW = (HALF > 1) ? $clog2(HALF) : 1;

  logic [CW-1:0] cnt_q;

  generate
    if (HALF == 1) begin : g_every
      assign tick_o = run_i;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cnt_q <= '0;
        else         cnt_q <= '0;
      end
    end else begin : g_count
      assign tick_o = run_i && (cnt_q == CW'(HALF - 1));
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)     cnt_q <= '0;
        else if (!run_i) cnt_q <= '0;
        else if (tick_o) cnt_q <= '0;
        else             cnt_q <= cnt_q + 1'b1;
      end
    end
  endgenerate
endmodule

// File: rtl/ftx_shift.sv
module ftx_shift #(
  parameter int unsigned W = 12
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic         shift_i,
  input  logic [W-1:0] word_i,
  output logic         msb_o
);
  logic [W-1:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      sh_q <= '0;
    else if (load_i)  sh_q <= word_i;
    else if (shift_i) sh_q <= {sh_q[W-2:0], 1'b0};
  end

  assign msb_o = sh_q[W-1];
endmodule

// File: rtl/frame_serial_tx.sv
module frame_serial_tx
  import ftx_pkg::*;
#(
  parameter int unsigned W   = 12,
  parameter int unsigned DIV = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic [W-1:0] word_i,
  output logic         bck_o,
  output logic         data_o,
  output logic         frame_o,
  output logic         busy_o
);
  localparam int unsigned HALF = DIV / 2;
  localparam int unsigned PW   = $clog2(W);

  ftx_state_e    state_q;
  logic [PW-1:0] idx_q;
  logic          bck_q, frame_q;
  logic          tick, load, shift, msb;

  assign load  = (state_q == ST_IDLE) && start_i;
  // shift on a falling edge that is not the last one
  assign shift = (state_q == ST_SEND) && tick && bck_q && (idx_q != PW'(W - 1));

  ftx_clk_div #(.HALF(HALF)) u_div (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .run_i (state_q != ST_IDLE),
    .tick_o(tick)
  );

  ftx_shift #(.W(W)) u_shift (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load),
    .shift_i(shift),
    .word_i (word_i),
    .msb_o  (msb)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      bck_q   <= 1'b0;
      frame_q <= 1'b1;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          state_q <= ST_SEND;
          idx_q   <= '0;
          frame_q <= 1'b0;
        end
        ST_SEND: if (tick) begin
          if (!bck_q) begin
            bck_q <= 1'b1;
          end else begin
            bck_q <= 1'b0;
            if (idx_q == PW'(W - 1)) begin
              state_q <= ST_GAP;
              frame_q <= 1'b1;
              idx_q   <= '0;
            end else begin
              idx_q <= idx_q + 1'b1;
            end
          end
        end
        ST_GAP: if (tick) begin
          if (idx_q == PW'(1)) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
          end else begin
            idx_q <= idx_q + 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign bck_o   = bck_q;
  assign frame_o = frame_q;
  assign data_o  = msb && (state_q == ST_SEND);
  assign busy_o  = (state_q != ST_IDLE);
endmodule

// File: rtl/ftx_checker.sv
module ftx_checker #(
  parameter int unsigned W = 12
) (
  input logic clk_i,
  input logic rst_ni,
  input logic bck_o,
  input logic data_o,
  input logic frame_o,
  input logic busy_o
);
  localparam int unsigned CW = $clog2(W + 1) + 1;

  logic [CW-1:0] rise_cnt;
  logic          bck_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rise_cnt <= '0;
      bck_d    <= 1'b0;
    end else begin
      bck_d <= bck_o;
      if (frame_o)            rise_cnt <= '0;
      else if (bck_o && !bck_d) rise_cnt <= rise_cnt + 1'b1;
    end
  end

  AST_BIT_COUNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(frame_o) |-> (rise_cnt == CW'(W))); // R1
  AST_DATA_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(bck_o) |-> $stable(data_o)); // R3
  AST_IDLE_DATA_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_o |-> !data_o); // R4
  AST_BCK_IDLE_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_o |-> !bck_o); // R5
  AST_RISE_IN_FRAME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(bck_o) |-> !frame_o); // R5
  AST_START_FROM_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(frame_o) |-> !$past(busy_o)); // R7
  AST_FRAME_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_o |-> busy_o); // R10
endmodule

bind frame_serial_tx ftx_checker #(.W(W)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .bck_o  (bck_o),
  .data_o (data_o),
  .frame_o(frame_o),
  .busy_o (busy_o)
);

// File: tb/frame_serial_tx_test.sv
module frame_serial_tx_test;
  localparam int W        = 12;
  localparam int DIV      = 2;
  localparam int HALF     = DIV / 2;
  localparam int CLK_PER  = 10;
  localparam int WD_LIMIT = 190000;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         start_i = 1'b0;
  logic [W-1:0] word_i = '0;
  logic         bck_o, data_o, frame_o, busy_o;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  bit done = 1'b0;

  frame_serial_tx #(.W(W), .DIV(DIV)) uut (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(start_i),
    .word_i (word_i),
    .bck_o  (bck_o),
    .data_o (data_o),
    .frame_o(frame_o),
    .busy_o (busy_o)
  );

  always #(CLK_PER / 2) clk_i = ~clk_i;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic check_idle(input string req);
    chk(frame_o == 1'b1, req, frame_o, 1);
    chk(bck_o == 1'b0, req, bck_o, 0);
    chk(data_o == 1'b0, req, data_o, 0);
    chk(busy_o == 1'b0, req, busy_o, 0);
  endtask

  // Sends w, switches word_i to w_after right after acceptance.
  task automatic run_frame(input logic [W-1:0] w, input logic [W-1:0] w_after, input bit poke);
    logic [W-1:0] got;
    int rises, low_cyc, first_rise, stab_err, gap;
    logic pb, pd;
    @(negedge clk_i);
    word_i  = w;
    start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    word_i  = w_after;
    got = '0; rises = 0; low_cyc = 0; first_rise = -1; stab_err = 0;
    pb = 1'b0; pd = 1'b0;
    chk(busy_o == 1'b1, "R10 busy at frame start", busy_o, 1);
    while (frame_o == 1'b0 && low_cyc < 1000) begin
      if (bck_o && !pb) begin
        rises++;
        got = {got[W-2:0], data_o};
        if (data_o != pd) stab_err++;
        if (first_rise < 0) first_rise = low_cyc;
      end
      low_cyc++;
      pb = bck_o;
      pd = data_o;
      if (poke && low_cyc == 5) start_i = 1'b1;
      if (poke && low_cyc == 6) start_i = 1'b0;
      @(negedge clk_i);
    end
    chk(rises == W, "R1 rising edges per frame", rises, W);
    chk(got == w, "R2/R8 received word", int'(got), int'(w));
    chk(stab_err == 0, "R3 data stable at rising edge", stab_err, 0);
    chk(low_cyc == W * DIV, "R4 frame length", low_cyc, W * DIV);
    chk(first_rise == HALF, "R6 first rising edge offset", first_rise, HALF);
    chk(bck_o == 1'b0, "R5 bit clock low after frame", bck_o, 0);
    gap = 0;
    while (busy_o && gap < 1000) begin
      gap++;
      @(negedge clk_i);
    end
    chk(gap == DIV, "R10 busy guard length", gap, DIV);
    if (poke) begin
      for (int i = 0; i < 2 * DIV; i++) begin
        chk(frame_o == 1'b1, "R7 mid-frame start ignored", frame_o, 1);
        @(negedge clk_i);
      end
    end
  endtask

  initial begin
    int hi;
    repeat (3) @(negedge clk_i);
    start_i = 1'b1;
    @(negedge clk_i);
    check_idle("R9 reset state");
    start_i = 1'b0;
    rst_ni = 1'b1;
    @(negedge clk_i);
    check_idle("R9 idle after reset");

    run_frame(12'hABD, 12'h542, 1'b0);          // R2 reference word
    run_frame(12'h000, 12'hFFF, 1'b0);          // R8
    run_frame(12'hFFF, 12'h000, 1'b1);          // R7
    for (int b = 0; b < W; b++) run_frame(W'(1) << b, ~(W'(1) << b), 1'b0);

    // R7 start held high: gap between frames
    @(negedge clk_i);
    word_i  = 12'h5A5;
    start_i = 1'b1;
    @(negedge clk_i);
    while (frame_o == 1'b0) @(negedge clk_i);
    hi = 0;
    while (frame_o == 1'b1 && hi < 1000) begin
      hi++;
      @(negedge clk_i);
    end
    chk(hi == DIV + 1, "R7 gap with start held", hi, DIV + 1);
    start_i = 1'b0;
    while (busy_o) @(negedge clk_i);

    // R9 reset mid-frame
    @(negedge clk_i);
    word_i  = 12'hFFF;
    start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    repeat (7) @(negedge clk_i);
    rst_ni = 1'b0;
    #1;
    check_idle("R9 reset mid-frame");
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check_idle("R9 idle after mid-frame reset");

    // exhaustive sweep
    for (int v = 0; v < (1 << W); v++) run_frame(W'(v), W'(~v), 1'b0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  always @(posedge clk_i) begin
    cyc++;
    if (cyc > WD_LIMIT && !done) begin
      done = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d cycles", cyc, WD_LIMIT);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule